// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It accepts a single request: program a word, erase a sector, erase the whole chip, or enable the boot-block write lock. It expands the request into the unlock and command write script that the flash expects. Each write cycle is timed in clock cycles derived from nanosecond parameters at the configured clock period. While a cycle is in flight, output enable stays high.

When the last write of a script has gone out, the block reads the status repeatedly from the request address. It stops when two reads in a row return the same value on data bit 6. If that does not happen within a poll limit, it reports a timeout, and erase operations have their own, longer limit. After a program operation finishes, one more read fetches the word at the target address and compares it with the requested data. The `done` pulse marks the end of every request. The `timeout_err` and `mismatch` flags are valid with that pulse and hold until the next request is accepted.

States: `ST_IDLE` waits for a request. `ST_SETUP` shows address and data with write enable high. `ST_PULSE` drives write enable low. `ST_HOLD` keeps the data after write enable rises. From `ST_HOLD` the block returns to `ST_SETUP` for the next script step, or moves to `ST_RD` after the final step. `ST_RD` is one status read with output enable low. `ST_GAP` is the output-enable-high interval between reads. `ST_RD` leads to `ST_GAP` when bit 6 changed, when there is no earlier read to compare with, or after a program completes. It leads to `ST_DONE` on a completed erase or lock, or when the limit is reached. `ST_GAP` goes back to `ST_RD`, or to `ST_VRD` once a program has completed. `ST_VRD` is the verify read. `ST_DONE` lasts one cycle and then returns to `ST_IDLE`.

Top module: `flash_cmd_seq`

## Requirements
- R1: Under reset and when idle, `f_ce_n`, `f_oe_n` and `f_we_n` are 1, and `f_dq_oe`, `busy` and `done` are 0.
- R2: A program request (`req_op`=0) issues exactly four writes as address/data pairs: 5555/AA, 2AAA/55, 5555/A0, then the request address with the request data.
- R3: Erase requests issue six writes. The first five are 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55. The sixth is the request address with 30 for sector erase (`req_op`=1), or 5555/10 for chip erase (`req_op`=2). Command bytes sit in data bits 7:0, with the upper bits zero.
- R4: A boot-lock request (`req_op`=3) issues the same five-write prefix as an erase, followed by 5555/40.
- R5: In every write cycle `f_we_n` is low for exactly ceil(T_WP_NS/CLK_NS) cycles. Address and data stay stable while it is low, data stays driven for ceil(T_DH_NS/CLK_NS) cycles after it rises, and `f_oe_n` stays high throughout.
- R6: Status reads use the request address and stop at the first read whose bit 6 equals that of the read before it. A device that toggles bit 6 K times therefore costs max(K+1,2) status reads.
- R7: Each read holds `f_oe_n` low for ceil(T_RD_NS/CLK_NS) cycles. Consecutive reads are separated by exactly ceil(T_GAP_NS/CLK_NS) cycles of `f_oe_n` high. `f_dq_oe` is 0 whenever `f_oe_n` is low.
- R8: A program whose status reads reach PROG_POLLS without a match ends with `timeout_err`=1, after exactly PROG_POLLS reads and no verify read.
- R9: An erase or lock request uses the separate limit ERASE_POLLS in the same way.
- R10: After a program completes without timeout, one further read at the request address is made. `mismatch` is 1 exactly when the returned word differs from the request data. Erase and lock requests leave it 0.
- R11: A request presented while `busy` is 1 is ignored: the script in progress and its write count are unchanged.
- R12: `done` is a single-cycle pulse, and `busy` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 boot lock |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Word to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| timeout_err | output | 1 | Poll limit reached |
| mismatch | output | 1 | Verify read differed from request data |
| f_addr | output | AW | Flash address |
| f_dout | output | DW | Flash write data |
| f_din | input | DW | Flash read data |
| f_dq_oe | output | 1 | Host drives the data bus |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_oe_n | output | 1 | Flash output enable, active low |
| f_we_n | output | 1 | Flash write enable, active low |

## Verification
Every result is due at a cycle that can be counted from the request. The request is taken at the first rising edge. Each write takes setup plus pulse plus hold cycles. Each read takes read cycles plus gap cycles. `done` follows one cycle after the last read. The bench keeps to this without predicting absolute cycles for the flags: it waits for `done` at falling edges and then one more cycle, and only then compares the flags and the monitor's logs, which keeps it clear of the edge at which the last read ends. A bus monitor in the bench measures every write-enable low interval, every read length and every inter-read gap, counting cycles at falling edges. A device model answers each read from the moment output enable falls, so the data is stable long before the controller samples it on the last read cycle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_LOCK = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_RD, ST_GAP, ST_VRD, ST_DONE
    } seq_st_e;

    // nanoseconds to whole clock cycles, never below one
    function automatic int ns2clk(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_delay_cnt.sv
module flash_delay_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/flash_cmd_script.sv
module flash_cmd_script
    import flash_seq_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  seq_op_e         op,
    input  logic [2:0]      step,
    input  logic [AW-1:0]   uaddr,
    input  logic [DW-1:0]   udata,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   data,
    output logic            last
);
    localparam logic [AW-1:0] A_HI = AW'(16'h5555);
    localparam logic [AW-1:0] A_LO = AW'(16'h2AAA);

    always_comb begin
        addr = A_HI;
        data = DW'(8'hAA);
        last = 1'b0;
        case (step)
            3'd0: ;
            3'd1: begin addr = A_LO; data = DW'(8'h55); end
            3'd2: data = (op == OP_PROG) ? DW'(8'hA0) : DW'(8'h80);
            3'd3: if (op == OP_PROG) begin
                      addr = uaddr;
                      data = udata;
                      last = 1'b1;
                  end
            3'd4: begin addr = A_LO; data = DW'(8'h55); end
            default: begin
                last = 1'b1;
                case (op)
                    OP_SECT: begin addr = uaddr; data = DW'(8'h30); end
                    OP_CHIP: data = DW'(8'h10);
                    default: data = DW'(8'h40);
                endcase
            end
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW          = 18,
    parameter int DW          = 16,
    parameter int CLK_NS      = 5,
    parameter int T_WP_NS     = 100,
    parameter int T_WPH_NS    = 50,
    parameter int T_DH_NS     = 10,
    parameter int T_RD_NS     = 90,
    parameter int T_GAP_NS    = 150,
    parameter int PROG_POLLS  = 64,
    parameter int ERASE_POLLS = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic          timeout_err,
    output logic          mismatch,
    output logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_dout,
    input  logic [DW-1:0] f_din,
    output logic          f_dq_oe,
    output logic          f_ce_n,
    output logic          f_oe_n,
    output logic          f_we_n
);
    localparam int C_SU  = ns2clk(T_WPH_NS, CLK_NS);
    localparam int C_WP  = ns2clk(T_WP_NS, CLK_NS);
    localparam int C_DH  = ns2clk(T_DH_NS, CLK_NS);
    localparam int C_RD  = ns2clk(T_RD_NS, CLK_NS);
    localparam int C_GAP = ns2clk(T_GAP_NS, CLK_NS);
    localparam int C_MAX = imax(imax(imax(C_SU, C_WP), imax(C_DH, C_RD)), C_GAP);
    localparam int TW    = $clog2(C_MAX + 1);
    localparam int PW    = $clog2(imax(PROG_POLLS, ERASE_POLLS) + 1);

    seq_st_e        state, nxt;
    seq_op_e        op_q;
    logic [2:0]     step;
    logic [AW-1:0]  addr_q, s_addr;
    logic [DW-1:0]  data_q, s_data;
    logic           s_last;
    logic           prev6, have_prev, fin_q;
    logic [PW-1:0]  polls, poll_lim;
    logic           tmr_load, tmr_zero, match, limit_hit;
    logic [TW-1:0]  tmr_val;

    flash_cmd_script #(.AW(AW), .DW(DW)) u_script (
        .op(op_q), .step(step), .uaddr(addr_q), .udata(data_q),
        .addr(s_addr), .data(s_data), .last(s_last)
    );

    flash_delay_cnt #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    assign poll_lim  = (op_q == OP_PROG) ? PW'(PROG_POLLS) : PW'(ERASE_POLLS);
    assign match     = have_prev && (f_din[6] == prev6);
    assign limit_hit = ((polls + 1'b1) == poll_lim);

    // next state and phase timer
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE:  if (req_valid) begin
                          nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = TW'(C_SU - 1);
                      end
            ST_SETUP: if (tmr_zero) begin
                          nxt = ST_PULSE; tmr_load = 1'b1; tmr_val = TW'(C_WP - 1);
                      end
            ST_PULSE: if (tmr_zero) begin
                          nxt = ST_HOLD; tmr_load = 1'b1; tmr_val = TW'(C_DH - 1);
                      end
            ST_HOLD:  if (tmr_zero) begin
                          tmr_load = 1'b1;
                          if (s_last) begin nxt = ST_RD;    tmr_val = TW'(C_RD - 1); end
                          else        begin nxt = ST_SETUP; tmr_val = TW'(C_SU - 1); end
                      end
            ST_RD:    if (tmr_zero) begin
                          if (match && op_q != OP_PROG)   nxt = ST_DONE;
                          else if (!match && limit_hit)   nxt = ST_DONE;
                          else begin
                              nxt = ST_GAP; tmr_load = 1'b1; tmr_val = TW'(C_GAP - 1);
                          end
                      end
            ST_GAP:   if (tmr_zero) begin
                          nxt = fin_q ? ST_VRD : ST_RD; tmr_load = 1'b1; tmr_val = TW'(C_RD - 1);
                      end
            ST_VRD:   if (tmr_zero) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            op_q        <= OP_PROG;
            step        <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            prev6       <= 1'b0;
            have_prev   <= 1'b0;
            fin_q       <= 1'b0;
            polls       <= '0;
            timeout_err <= 1'b0;
            mismatch    <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && req_valid) begin
                op_q        <= seq_op_e'(req_op);
                addr_q      <= req_addr;
                data_q      <= req_data;
                step        <= '0;
                fin_q       <= 1'b0;
                timeout_err <= 1'b0;
                mismatch    <= 1'b0;
            end
            if (state == ST_HOLD && tmr_zero) begin
                if (s_last) begin
                    polls     <= '0;
                    have_prev <= 1'b0;
                end else begin
                    step <= step + 3'd1;
                end
            end
            if (state == ST_RD && tmr_zero) begin
                prev6     <= f_din[6];
                have_prev <= 1'b1;
                polls     <= polls + 1'b1;
                if (match && op_q == OP_PROG) fin_q       <= 1'b1;
                if (!match && limit_hit)      timeout_err <= 1'b1;
            end
            if (state == ST_VRD && tmr_zero)
                mismatch <= (f_din != data_q);
        end
    end

    // bus and status outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        f_we_n  = (state != ST_PULSE);
        f_oe_n  = !(state == ST_RD || state == ST_VRD);
        f_dq_oe = (state == ST_SETUP || state == ST_PULSE || state == ST_HOLD);
        f_ce_n  = (state == ST_IDLE || state == ST_DONE);
        f_addr  = f_dq_oe ? s_addr : addr_q;
        f_dout  = s_data;
    end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] f_addr,
    input logic [DW-1:0] f_dout,
    input logic          f_dq_oe,
    input logic          f_oe_n,
    input logic          f_we_n
);
    // R5
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we_n |-> f_oe_n);

    // R5
    pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_we_n && !$past(f_we_n)) |-> ($stable(f_addr) && $stable(f_dout)));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_we_n) |-> (f_dq_oe && $stable(f_dout)));

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_oe_n |-> !f_dq_oe);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .f_addr(f_addr),
    .f_dout(f_dout), .f_dq_oe(f_dq_oe), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;
    localparam int AW    = 18;
    localparam int DW    = 16;
    localparam int C_WP  = (100 + 4) / 5;
    localparam int C_RD  = (90 + 4) / 5;
    localparam int C_GAP = (150 + 4) / 5;
    localparam int LIM_P = 64;
    localparam int LIM_E = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, done, timeout_err, mismatch;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] f_dout;
    logic [DW-1:0] f_din = '0;
    logic          f_dq_oe, f_ce_n, f_oe_n, f_we_n;

    int nchk = 0;
    int nfail = 0;

    // monitor / model state
    int            we_lo = 0, oe_lo = 0, oe_hi = 0, wr_n = 0, rd_n = 0;
    int            pulse_bad = 0, rdlen_bad = 0, gap_bad = 0, addr_bad = 0, oe_wr_bad = 0;
    logic          pwe = 1'b1, poe = 1'b1;
    logic [AW-1:0] la, ra0;
    logic [DW-1:0] ld;
    logic [AW-1:0] wa [16];
    logic [DW-1:0] wd [16];
    int            rem = 0;
    logic          tb6 = 1'b0;
    logic [DW-1:0] memv = '0;

    always #2.5 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .timeout_err(timeout_err), .mismatch(mismatch), .f_addr(f_addr),
        .f_dout(f_dout), .f_din(f_din), .f_dq_oe(f_dq_oe), .f_ce_n(f_ce_n),
        .f_oe_n(f_oe_n), .f_we_n(f_we_n)
    );

    // bus monitor and device model
    always @(negedge clk) begin
        if (rst_n) begin
            if (!f_we_n) begin
                we_lo++; la = f_addr; ld = f_dout;
                if (!f_oe_n) oe_wr_bad++;
            end else if (!pwe) begin
                if (we_lo != C_WP) pulse_bad++;
                if (wr_n < 16) begin wa[wr_n] = la; wd[wr_n] = ld; end
                wr_n++; we_lo = 0;
            end
            if (!f_oe_n) begin
                if (poe) begin
                    if (rd_n > 0 && oe_hi != C_GAP) gap_bad++;
                    if (rd_n == 0) ra0 = f_addr;
                    else if (f_addr != ra0) addr_bad++;
                    if (rem > 0) begin
                        tb6 = ~tb6; rem--;
                        f_din <= (memv & ~16'h0040) | {9'd0, tb6, 6'd0};
                    end else begin
                        f_din <= memv;
                    end
                    rd_n++; oe_lo = 0;
                end
                oe_lo++;
            end else begin
                if (!poe) begin
                    if (oe_lo != C_RD) rdlen_bad++;
                    oe_hi = 0;
                end
                oe_hi++;
            end
        end
        pwe = f_we_n; poe = f_oe_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ex_a(input int op, input int i, input logic [AW-1:0] ua);
        case (i)
            0, 2:    return AW'(16'h5555);
            1, 4:    return AW'(16'h2AAA);
            3:       return (op == 0) ? ua : AW'(16'h5555);
            default: return (op == 1) ? ua : AW'(16'h5555);
        endcase
    endfunction

    function automatic logic [DW-1:0] ex_d(input int op, input int i, input logic [DW-1:0] ud);
        case (i)
            0:       return 16'h00AA;
            1, 4:    return 16'h0055;
            2:       return (op == 0) ? 16'h00A0 : 16'h0080;
            3:       return (op == 0) ? ud : 16'h00AA;
            default: return (op == 1) ? 16'h0030 : (op == 2) ? 16'h0010 : 16'h0040;
        endcase
    endfunction

    task automatic run_op(input int op, input logic [AW-1:0] ua, input logic [DW-1:0] ud,
                          input int k, input bit corrupt, input bit inject);
        int cyc, kk, lim, nwr, nrd;
        bit to, mis;
        string tw;
        memv = (op == 0) ? (ud ^ (corrupt ? 16'h0001 : 16'h0000)) : 16'hFFFF;
        rem = k; tb6 = memv[6] ^ k[0];
        wr_n = 0; rd_n = 0; pulse_bad = 0; rdlen_bad = 0; gap_bad = 0; addr_bad = 0; oe_wr_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = ua; req_data = ud;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 40) begin
                req_valid = 1'b1; req_op = 2'd2; req_addr = ~ua;
            end
            if (cyc == 41) req_valid = 1'b0;
            if (done || cyc > 60000) break;
        end
        chk(done, "R12 done seen", int'(done), 1);
        @(negedge clk);
        chk(!busy && !done, "R12 busy low after done", int'(busy), 0);
        kk  = (k + 1 < 2) ? 2 : k + 1;
        lim = (op == 0) ? LIM_P : LIM_E;
        to  = kk > lim;
        mis = (op == 0) && corrupt && !to;
        nwr = (op == 0) ? 4 : 6;
        nrd = to ? lim : kk + ((op == 0) ? 1 : 0);
        tw  = (op == 0) ? "R2" : (op == 3) ? "R4" : "R3";
        chk(wr_n == nwr, inject ? "R11 write count" : {tw, " write count"}, wr_n, nwr);
        for (int i = 0; i < nwr && i < wr_n; i++) begin
            chk(wa[i] == ex_a(op, i, ua), {tw, " write address"}, int'(wa[i]), int'(ex_a(op, i, ua)));
            chk(wd[i] == ex_d(op, i, ud), {tw, " write data"}, int'(wd[i]), int'(ex_d(op, i, ud)));
        end
        chk(pulse_bad == 0 && oe_wr_bad == 0, "R5 write pulse timing", pulse_bad + oe_wr_bad, 0);
        chk(rd_n == nrd, "R6 read count", rd_n, nrd);
        chk(addr_bad == 0 && ra0 == ua, "R6 read address", int'(ra0), int'(ua));
        chk(rdlen_bad == 0 && gap_bad == 0, "R7 read timing", rdlen_bad + gap_bad, 0);
        chk(timeout_err == to, (op == 0) ? "R8 timeout flag" : "R9 timeout flag", int'(timeout_err), int'(to));
        chk(mismatch == mis, "R10 mismatch flag", int'(mismatch), int'(mis));
    endtask

    initial begin
        #(5.0 * 200000);
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(f_ce_n && f_oe_n && f_we_n && !f_dq_oe && !busy && !done,
            "R1 outputs in reset", {f_ce_n, f_oe_n, f_we_n, f_dq_oe, busy, done}, 6'b111000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(f_ce_n && f_oe_n && f_we_n && !f_dq_oe && !busy,
            "R1 idle outputs", {f_ce_n, f_oe_n, f_we_n, f_dq_oe, busy}, 5'b11100);

        run_op(0, 18'h01234, 16'hBEEF, 0, 1'b0, 1'b0);  // R2 R6 minimum two reads
        run_op(0, 18'h3FFFF, 16'h0F0F, 3, 1'b1, 1'b0);  // R10 mismatch
        run_op(1, 18'h3C000, 16'h0000, 2, 1'b0, 1'b0);  // R3 sector
        run_op(2, 18'h00000, 16'h0000, 1, 1'b0, 1'b0);  // R3 chip
        run_op(3, 18'h02002, 16'h0000, 0, 1'b0, 1'b0);  // R4
        run_op(0, 18'h00ABC, 16'h1234, 3, 1'b0, 1'b1);  // R11 injected request
        for (int n = 0; n < 8; n++) begin
            int op, k;
            bit cr;
            op = int'($urandom_range(0, 3));
            k  = int'($urandom_range(0, 6));
            cr = (op == 0) && ($urandom_range(0, 1) == 1);
            run_op(op, AW'($urandom), DW'($urandom), k, cr, 1'b0);
        end
        run_op(0, 18'h00100, 16'h5A5A, 1000, 1'b0, 1'b0); // R8
        run_op(1, 18'h10000, 16'h0000, 1000, 1'b0, 1'b0); // R9
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule